// File: doc/BRIEF.md
# Interconnect Traffic Statistics Collector

A passive monitor attached to one on-chip interconnect link that has a request channel and a response channel. It counts traffic events over a sampling window whose length software sets. At the close of each window it latches the raw totals into a report register, pulses a one-cycle strobe for a trace or streaming port, and starts the next window at once. It never stalls or alters the traffic it watches.

The report carries the raw material for the usual link metrics. Software turns these counts into averages and percentages. Bytes and packet count give the mean burst length. Bytes and window cycles give the throughput. Store-cycle and load-cycle counts give the link occupancy for each direction. The arbitration-conflict and initiator-busy cycle counts give the stall ratios. The report also holds two four-bin histograms, one of payload length and one of QoS level.

Top module: `traffic_stats_collector`

## Requirements
- R1: With a nonzero window length L in force, every L consecutive cycles form one window. `rpt_valid_o` is high for exactly the one cycle that follows the last cycle of each window, and `rpt_cycles_o` then equals L.
- R2: If `win_len_i` is 0 when a window boundary is reached (or while collection is idle), collection stops. No strobe is issued and nothing accumulates until a nonzero length is sampled. Collection then starts on the following cycle.
- R3: `win_len_i` is sampled only at a window boundary (or while idle). A change written in mid-window does not alter the window in progress.
- R4: A packet is a cycle with `req_valid_i` and `req_ready_i` both high. `rpt_pkts_o` counts packets in the window, and `rpt_bytes_o` sums their `req_bytes_i`.
- R5: Each packet adds one to a payload-length bin in `rpt_len_hist_o`. Bin 0 (bits [W-1:0]) covers bytes < 16. Bin 1 covers 16 to 31. Bin 2 covers 32 to 127. Bin 3 covers 128 and above. Each lower edge belongs to the higher bin.
- R6: Each packet adds one to bin `req_qos_i` of `rpt_qos_hist_o`, where bin n sits at bits [n*W +: W].
- R7: `rpt_st_occ_o` counts the cycles with `req_valid_i` high and `req_store_i` = 1 (store).
- R8: `rpt_ld_occ_o` counts the cycles with `rsp_valid_i` high (load return).
- R9: `rpt_arb_o` counts the cycles with `arb_stall_i` high, and `rpt_busy_o` counts the cycles with `init_busy_i` high.
- R10: Every count saturates at its all-ones value instead of wrapping.
- R11: Each enabled cycle falls in exactly one window. Events in the strobe cycle belong to the new window. Report fields hold their value between strobes.
- R12: After reset all report outputs and `rpt_valid_o` are 0, and collection is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_len_i | input | WIN_W | Window length in cycles; 0 disables |
| req_valid_i | input | 1 | Request channel valid |
| req_ready_i | input | 1 | Request channel ready |
| req_store_i | input | 1 | Request direction: 1 store, 0 load |
| req_bytes_i | input | LEN_W | Payload length of the request in bytes |
| req_qos_i | input | QOS_W | QoS level of the request |
| rsp_valid_i | input | 1 | Response channel carries load data |
| arb_stall_i | input | 1 | Request link lost arbitration this cycle |
| init_busy_i | input | 1 | Initiator busy on the response link |
| rpt_valid_o | output | 1 | Report strobe, one cycle per window |
| rpt_cycles_o | output | WIN_W | Length of the reported window |
| rpt_bytes_o | output | BYTE_W | Total payload bytes |
| rpt_pkts_o | output | CNT_W | Packet count |
| rpt_st_occ_o | output | CNT_W | Store-occupied request cycles |
| rpt_ld_occ_o | output | CNT_W | Load-occupied response cycles |
| rpt_arb_o | output | CNT_W | Arbitration-conflict cycles |
| rpt_busy_o | output | CNT_W | Initiator-busy cycles |
| rpt_len_hist_o | output | 4*CNT_W | Payload-length histogram |
| rpt_qos_hist_o | output | (2**QOS_W)*CNT_W | QoS histogram |

## Verification
A wrong window position or length shows up as a strobe in the wrong cycle or as a wrong `rpt_cycles_o`. Either becomes visible at the next window boundary, at most L cycles later. A lost, doubled or misbinned event shows up as a wrong count or a histogram whose sum differs from the packet count, in the very next report. A counter that wraps instead of saturating shows as a small value where all-ones is due. Comparing every cycle against a behavioural model catches these faults within one window of the cause.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned LEN_BINS = 4;

  typedef enum logic [1:0] {
    BIN_SMALL = 2'd0,
    BIN_MID   = 2'd1,
    BIN_LARGE = 2'd2,
    BIN_OVER  = 2'd3
  } len_bin_e;
endpackage

// File: rtl/tsc_window_ctrl.sv
module tsc_window_ctrl #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             run_o,
  output logic             close_o,
  output logic [WIN_W-1:0] len_o
);
  logic [WIN_W-1:0] len_q, pos_q;

  assign run_o   = (len_q != '0);
  assign close_o = run_o && (pos_q == len_q - WIN_W'(1));
  assign len_o   = len_q;

  // length is only resampled while idle or on the last cycle of a window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      pos_q <= '0;
    end else if (!run_o || close_o) begin
      len_q <= win_len_i;
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + WIN_W'(1);
    end
  end
endmodule

// File: rtl/tsc_sat_cnt.sv
module tsc_sat_cnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          close_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  rpt_o
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  acc_q, rpt_q, nxt;
  logic [SW-1:0] sum;

  assign sum   = {1'b0, acc_q} + SW'(inc_i);
  assign nxt   = sum[W] ? '1 : sum[W-1:0];
  assign rpt_o = rpt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rpt_q <= '0;
    end else begin
      if (close_i) rpt_q <= nxt;
      // closing cycle's events go into the report; the next window starts empty
      if (!run_i || close_i) acc_q <= '0;
      else                   acc_q <= nxt;
    end
  end
endmodule

// File: rtl/tsc_len_binner.sv
module tsc_len_binner
  import tsc_pkg::*;
#(
  parameter int unsigned LEN_W = 10,
  parameter int unsigned EDGE0 = 16,
  parameter int unsigned EDGE1 = 32,
  parameter int unsigned EDGE2 = 128
) (
  input  logic [LEN_W-1:0] len_i,
  output len_bin_e         bin_o
);
  localparam int unsigned CW = LEN_W + 1;

  always_comb begin
    if      (CW'(len_i) < CW'(EDGE0)) bin_o = BIN_SMALL;
    else if (CW'(len_i) < CW'(EDGE1)) bin_o = BIN_MID;
    else if (CW'(len_i) < CW'(EDGE2)) bin_o = BIN_LARGE;
    else                              bin_o = BIN_OVER;
  end
endmodule

// File: rtl/traffic_stats_collector.sv
module traffic_stats_collector
  import tsc_pkg::*;
#(
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 24,
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned QOS_W  = 2,
  localparam int unsigned NQ    = 1 << QOS_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WIN_W-1:0]         win_len_i,
  input  logic                     req_valid_i,
  input  logic                     req_ready_i,
  input  logic                     req_store_i,
  input  logic [LEN_W-1:0]         req_bytes_i,
  input  logic [QOS_W-1:0]         req_qos_i,
  input  logic                     rsp_valid_i,
  input  logic                     arb_stall_i,
  input  logic                     init_busy_i,
  output logic                     rpt_valid_o,
  output logic [WIN_W-1:0]         rpt_cycles_o,
  output logic [BYTE_W-1:0]        rpt_bytes_o,
  output logic [CNT_W-1:0]         rpt_pkts_o,
  output logic [CNT_W-1:0]         rpt_st_occ_o,
  output logic [CNT_W-1:0]         rpt_ld_occ_o,
  output logic [CNT_W-1:0]         rpt_arb_o,
  output logic [CNT_W-1:0]         rpt_busy_o,
  output logic [LEN_BINS*CNT_W-1:0] rpt_len_hist_o,
  output logic [NQ*CNT_W-1:0]      rpt_qos_hist_o
);
  logic             run, close, pkt;
  logic [WIN_W-1:0] len_cur;
  logic [LEN_W-1:0] bytes_inc;
  len_bin_e         len_bin;
  logic [1:0]       len_idx;
  logic             valid_q;
  logic [WIN_W-1:0] cycles_q;

  assign pkt       = req_valid_i && req_ready_i;
  assign bytes_inc = pkt ? req_bytes_i : '0;
  assign len_idx   = len_bin;

  tsc_window_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk_i, .rst_ni, .win_len_i,
    .run_o(run), .close_o(close), .len_o(len_cur)
  );

  tsc_len_binner #(.LEN_W(LEN_W)) u_bin (.len_i(req_bytes_i), .bin_o(len_bin));

  tsc_sat_cnt #(.W(BYTE_W), .IW(LEN_W)) u_bytes (
    .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(bytes_inc), .rpt_o(rpt_bytes_o));
  tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_pkts (
    .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(pkt), .rpt_o(rpt_pkts_o));
  tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_st (
    .clk_i, .rst_ni, .run_i(run), .close_i(close),
    .inc_i(req_valid_i && req_store_i), .rpt_o(rpt_st_occ_o));
  tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_ld (
    .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(rsp_valid_i), .rpt_o(rpt_ld_occ_o));
  tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_arb (
    .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(arb_stall_i), .rpt_o(rpt_arb_o));
  tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_busy (
    .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(init_busy_i), .rpt_o(rpt_busy_o));

  for (genvar b = 0; b < LEN_BINS; b++) begin : g_len
    logic hit;
    assign hit = pkt && (len_idx == 2'(b));
    tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_cnt (
      .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(hit),
      .rpt_o(rpt_len_hist_o[b*CNT_W +: CNT_W]));
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qos
    logic hit;
    assign hit = pkt && (req_qos_i == QOS_W'(q));
    tsc_sat_cnt #(.W(CNT_W), .IW(1)) u_cnt (
      .clk_i, .rst_ni, .run_i(run), .close_i(close), .inc_i(hit),
      .rpt_o(rpt_qos_hist_o[q*CNT_W +: CNT_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      cycles_q <= '0;
    end else begin
      valid_q <= close;
      if (close) cycles_q <= len_cur;
    end
  end

  assign rpt_valid_o  = valid_q;
  assign rpt_cycles_o = cycles_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned QOS_W = 2,
  localparam int unsigned NQ   = 1 << QOS_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rpt_valid_o,
  input logic [WIN_W-1:0]     rpt_cycles_o,
  input logic [CNT_W-1:0]     rpt_pkts_o,
  input logic [CNT_W-1:0]     rpt_st_occ_o,
  input logic [CNT_W-1:0]     rpt_ld_occ_o,
  input logic [CNT_W-1:0]     rpt_arb_o,
  input logic [CNT_W-1:0]     rpt_busy_o,
  input logic [4*CNT_W-1:0]   rpt_len_hist_o,
  input logic [NQ*CNT_W-1:0]  rpt_qos_hist_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned SW = CNT_W + QOS_W + 2;

  logic [SW-1:0] len_sum, qos_sum;

  always_comb begin
    len_sum = '0;
    for (int i = 0; i < 4; i++) len_sum = len_sum + SW'(rpt_len_hist_o[i*CNT_W +: CNT_W]);
    qos_sum = '0;
    for (int i = 0; i < NQ; i++) qos_sum = qos_sum + SW'(rpt_qos_hist_o[i*CNT_W +: CNT_W]);
  end

  // R1
  win_len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> rpt_cycles_o != '0);
  // R4
  pkts_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> 32'(rpt_pkts_o) <= 32'(rpt_cycles_o));
  // R5
  len_hist_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_pkts_o != CNT_MAX) |-> len_sum == SW'(rpt_pkts_o));
  // R6
  qos_hist_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_o && rpt_pkts_o != CNT_MAX) |-> qos_sum == SW'(rpt_pkts_o));
  // R7
  st_occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> 32'(rpt_st_occ_o) <= 32'(rpt_cycles_o));
  // R8
  ld_occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> 32'(rpt_ld_occ_o) <= 32'(rpt_cycles_o));
  // R9
  stall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> (32'(rpt_arb_o) <= 32'(rpt_cycles_o)) && (32'(rpt_busy_o) <= 32'(rpt_cycles_o)));
  // R11
  rpt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rpt_valid_o |-> $stable(rpt_pkts_o) && $stable(rpt_cycles_o) && $stable(rpt_len_hist_o));
endmodule

bind traffic_stats_collector tsc_checker #(
  .WIN_W(WIN_W), .CNT_W(CNT_W), .QOS_W(QOS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rpt_valid_o(rpt_valid_o), .rpt_cycles_o(rpt_cycles_o),
  .rpt_pkts_o(rpt_pkts_o), .rpt_st_occ_o(rpt_st_occ_o), .rpt_ld_occ_o(rpt_ld_occ_o),
  .rpt_arb_o(rpt_arb_o), .rpt_busy_o(rpt_busy_o), .rpt_len_hist_o(rpt_len_hist_o),
  .rpt_qos_hist_o(rpt_qos_hist_o)
);

// File: tb/traffic_stats_collector_tb.sv
module traffic_stats_collector_tb;
  localparam int WW = 10, CW = 8, BW = 12, LW = 9, QW = 2, NQ = 4;
  localparam int NF = 14; // 0 bytes,1 pkts,2 st,3 ld,4 arb,5 busy,6..9 len,10..13 qos

  logic clk_i = 0, rst_ni = 0;
  logic [WW-1:0] win_len_i = '0;
  logic req_valid_i = 0, req_ready_i = 0, req_store_i = 0;
  logic [LW-1:0] req_bytes_i = '0;
  logic [QW-1:0] req_qos_i = '0;
  logic rsp_valid_i = 0, arb_stall_i = 0, init_busy_i = 0;
  logic rpt_valid_o;
  logic [WW-1:0] rpt_cycles_o;
  logic [BW-1:0] rpt_bytes_o;
  logic [CW-1:0] rpt_pkts_o, rpt_st_occ_o, rpt_ld_occ_o, rpt_arb_o, rpt_busy_o;
  logic [4*CW-1:0] rpt_len_hist_o;
  logic [NQ*CW-1:0] rpt_qos_hist_o;

  always #4 clk_i = ~clk_i;

  traffic_stats_collector #(.WIN_W(WW), .CNT_W(CW), .BYTE_W(BW), .LEN_W(LW), .QOS_W(QW)) u_dut (
    .clk_i, .rst_ni, .win_len_i, .req_valid_i, .req_ready_i, .req_store_i, .req_bytes_i,
    .req_qos_i, .rsp_valid_i, .arb_stall_i, .init_busy_i, .rpt_valid_o, .rpt_cycles_o,
    .rpt_bytes_o, .rpt_pkts_o, .rpt_st_occ_o, .rpt_ld_occ_o, .rpt_arb_o, .rpt_busy_o,
    .rpt_len_hist_o, .rpt_qos_hist_o);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_len, m_pos, m_rcyc;
  bit m_rv;
  int m_acc[NF], m_rpt[NF];

  function automatic int bin_of(int b);
    if (b < 16) return 0;
    if (b < 32) return 1;
    if (b < 128) return 2;
    return 3;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_len = 0; m_pos = 0; m_rv = 0; m_rcyc = 0;
      for (int f = 0; f < NF; f++) begin m_acc[f] = 0; m_rpt[f] = 0; end
    end else begin
      int inc[NF];
      bit p;
      p = req_valid_i && req_ready_i;
      for (int f = 0; f < NF; f++) inc[f] = 0;
      inc[0] = p ? int'(req_bytes_i) : 0;
      inc[1] = p;
      inc[2] = req_valid_i && req_store_i;
      inc[3] = rsp_valid_i;
      inc[4] = arb_stall_i;
      inc[5] = init_busy_i;
      if (p) begin
        inc[6 + bin_of(int'(req_bytes_i))] = 1;
        inc[10 + int'(req_qos_i)] = 1;
      end
      if (m_len == 0) begin
        m_rv = 0; m_len = int'(win_len_i); m_pos = 0;
        for (int f = 0; f < NF; f++) m_acc[f] = 0;
      end else begin
        bit last;
        last = (m_pos == m_len - 1);
        for (int f = 0; f < NF; f++) begin
          int mx, nv;
          mx = (f == 0) ? (1 << BW) - 1 : (1 << CW) - 1;
          nv = m_acc[f] + inc[f];
          if (nv > mx) nv = mx;
          if (last) begin m_rpt[f] = nv; m_acc[f] = 0; end
          else m_acc[f] = nv;
        end
        if (last) begin
          m_rv = 1; m_rcyc = m_len; m_len = int'(win_len_i); m_pos = 0;
        end else begin
          m_rv = 0; m_pos++;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1 strobe", int'(rpt_valid_o), int'(m_rv));
      chk("R1 cycles", int'(rpt_cycles_o), m_rcyc);
      chk("R4 bytes", int'(rpt_bytes_o), m_rpt[0]);
      chk("R4 pkts", int'(rpt_pkts_o), m_rpt[1]);
      chk("R7 store occupancy", int'(rpt_st_occ_o), m_rpt[2]);
      chk("R8 load occupancy", int'(rpt_ld_occ_o), m_rpt[3]);
      chk("R9 arb conflict", int'(rpt_arb_o), m_rpt[4]);
      chk("R9 initiator busy", int'(rpt_busy_o), m_rpt[5]);
      for (int i = 0; i < 4; i++)
        chk("R5 length bin", int'(rpt_len_hist_o[i*CW +: CW]), m_rpt[6+i]);
      for (int i = 0; i < NQ; i++)
        chk("R6 qos bin", int'(rpt_qos_hist_o[i*CW +: CW]), m_rpt[10+i]);
    end
  end

  task automatic idle_inputs();
    req_valid_i = 0; req_ready_i = 0; req_store_i = 0; req_bytes_i = '0;
    req_qos_i = '0; rsp_valid_i = 0; arb_stall_i = 0; init_busy_i = 0;
  endtask

  task automatic wait_strobe();
    @(negedge clk_i);
    while (!rpt_valid_o) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual expired expected finish");
      finish_run();
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 reset strobe", int'(rpt_valid_o), 0);
    chk("R12 reset pkts", int'(rpt_pkts_o), 0);
    chk("R12 reset bytes", int'(rpt_bytes_o), 0);
    chk("R12 reset cycles", int'(rpt_cycles_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R5 bin edges and R6 qos bins, one window of 4
    win_len_i = 4;
    @(negedge clk_i);
    req_valid_i = 1; req_ready_i = 1;
    for (int k = 0; k < 4; k++) begin
      req_bytes_i = LW'((k == 0) ? 15 : (k == 1) ? 16 : (k == 2) ? 127 : 128);
      req_qos_i = QW'(k);
      @(negedge clk_i);
    end
    idle_inputs();
    chk("R1 directed strobe", int'(rpt_valid_o), 1);
    chk("R4 directed bytes", int'(rpt_bytes_o), 286);
    for (int i = 0; i < 4; i++) begin
      chk("R5 directed bin", int'(rpt_len_hist_o[i*CW +: CW]), 1);
      chk("R6 directed bin", int'(rpt_qos_hist_o[i*CW +: CW]), 1);
    end

    // R11 continuous traffic, nothing lost across boundaries
    win_len_i = 3;
    req_valid_i = 1; req_ready_i = 1; req_bytes_i = LW'(8);
    wait_strobe();
    for (int k = 0; k < 2; k++) begin
      wait_strobe();
      chk("R11 pkts per window", int'(rpt_pkts_o), 3);
      chk("R11 cycles per window", int'(rpt_cycles_o), 3);
    end

    // R3 mid-window change waits for the boundary
    win_len_i = 6;
    wait_strobe();
    chk("R3 old length kept", int'(rpt_cycles_o), 3);
    wait_strobe();
    chk("R3 new length applied", int'(rpt_cycles_o), 6);
    chk("R3 pkts new window", int'(rpt_pkts_o), 6);

    // R2 disable
    win_len_i = 0;
    wait_strobe();
    seen = 0;
    repeat (20) begin
      @(negedge clk_i);
      if (rpt_valid_o) seen++;
    end
    chk("R2 no strobe while disabled", seen, 0);

    // R10 saturation
    win_len_i = 300; req_store_i = 1; req_bytes_i = LW'(200);
    wait_strobe();
    wait_strobe();
    chk("R10 pkts saturate", int'(rpt_pkts_o), 255);
    chk("R10 bytes saturate", int'(rpt_bytes_o), 4095);
    chk("R10 store occupancy saturates", int'(rpt_st_occ_o), 255);
    idle_inputs();

    // random traffic, model compare every cycle; last phases toggle length (R3)
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        if (ph >= 6) begin
          if ($urandom_range(0, 9) == 0) win_len_i = WW'($urandom_range(0, 12));
        end else if (c == 0) begin
          win_len_i = WW'((ph == 0) ? 1 : (ph == 1) ? 7 : (ph == 2) ? 20 :
                          (ph == 3) ? 0 : (ph == 4) ? 2 : 33);
        end
        req_valid_i = $urandom_range(0, 1);
        req_ready_i = $urandom_range(0, 2) != 0;
        req_store_i = $urandom_range(0, 1);
        req_bytes_i = LW'($urandom_range(0, 300));
        req_qos_i = QW'($urandom_range(0, 3));
        rsp_valid_i = $urandom_range(0, 1);
        arb_stall_i = $urandom_range(0, 3) == 0;
        init_busy_i = $urandom_range(0, 2) == 0;
        @(negedge clk_i);
      end
    end
    idle_inputs();
    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule